// File: doc/BRIEF.md
# Four-Channel Shadow-Loaded PWM

This block produces one pulse-width-modulated pin per channel from a common clock. Each channel is set up through a 32-bit register bus with a period and a low-time, both counted in clock cycles. Setting the channel's run bit takes a working copy of both values and starts the counter. Each period is high for `period - low_time` cycles and then low for `low_time` cycles, so a low-time of zero holds the pin high.

New values can be written at any time, but a running channel ignores them until software writes the channel's update bit to 1 and then back to 0. The values are copied when that bit falls. The copy is applied at the end of the current period, so no short pulse appears. Each applied update sets a sticky done bit, which software clears by writing 1 to it. The pin is held low while the channel is stopped or its output-enable bit is clear. A polarity register can be written and read back, but it does not change the output, because only normal polarity is supported.

Top module: `pwm_multi`

## Requirements
- R1: After reset every pin is low and every register reads zero.
- R2: When a channel's run bit changes from 0 to 1, the channel copies its period and low-time registers into its working values. The counter starts at zero, and the pin is high in the second cycle after the write.
- R3: While running with working period P and low-time L < P, the pin is high for P−L cycles and then low for L cycles, and this repeats. If L ≥ P the pin stays low. The fastest waveform uses P = 2.
- R4: The pin is low whenever the channel's output-enable bit is clear. It is also low from the second cycle after the run bit is cleared.
- R5: A low-time of 0 holds the pin constantly high while the channel runs with output enabled.
- R6: While a channel runs, writes to its period or low-time register do not change the waveform until an update pulse is given.
- R7: A 1-then-0 write sequence on the channel's update bit (bit n of offset 0x4C) captures the register values when the bit falls. The captured values take effect when the current period ends, and the new period starts with its counter at zero.
- R8: Bit n of the done register (offset 0x48) becomes 1 when an update is applied to channel n. It stays 1 until software writes 1 to that bit.
- R9: Clearing the run bit returns the counter to zero. A later restart begins a fresh period with the pin high.
- R10: The period and low-time fields are 30 bits wide, and bits 31:30 read as zero. The run, update, done, output-enable and polarity registers use bits [3:0] only, and their upper bits read as zero.
- R11: The polarity register (offset 0x40) stores and reads back its bits but has no effect on any pin.
- R12: The register map is as follows. Low-time is at 0x00+8n, period at 0x04+8n, run at 0x44 and output-enable at 0xD0. In each bit register, bit n belongs to channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for counters and registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational decode of bus_addr |
| pwm_o | output | 4 | One PWM pin per channel |

## Verification
The hardest case to reach is an update pulse that arrives partway through a period, followed by several boundaries. The check needs the captured values to stay pending until the period ends, and then needs the done bit to be set and cleared correctly. The bench gets there with directed sequences that rewrite the registers on a running channel and give the two-write update pulse. Random operations then pulse update, toggle run and output-enable, and write out-of-range low-times on running channels at random phases. A cycle-level model in the bench, driven only by the bus traffic, predicts every pin on every cycle.

// File: rtl/pwm_multi_pkg.sv
package pwm_multi_pkg;
  localparam int unsigned PER_W = 30;
  localparam int unsigned BUS_W = 32;

  localparam logic [7:0] OFS_POL  = 8'h40;
  localparam logic [7:0] OFS_RUN  = 8'h44;
  localparam logic [7:0] OFS_DONE = 8'h48;
  localparam logic [7:0] OFS_UPD  = 8'h4C;
  localparam logic [7:0] OFS_OE   = 8'hD0;

  typedef logic [PER_W-1:0] tick_t;

  // Number of high cycles in one period.
  function automatic tick_t high_span(tick_t per, tick_t low);
    return (low >= per) ? '0 : tick_t'(per - low);
  endfunction

  // Pin level for a given count.
  function automatic logic drive_high(tick_t cnt, tick_t per, tick_t low);
    return cnt < high_span(per, low);
  endfunction

  // Last cycle of a period.
  function automatic logic at_end(tick_t cnt, tick_t per);
    return ({1'b0, cnt} + (PER_W+1)'(1)) >= {1'b0, per};
  endfunction
endpackage

// File: rtl/pwm_multi_regs.sv
module pwm_multi_regs
  import pwm_multi_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [AW-1:0]               addr,
  input  logic [BUS_W-1:0]            wdata,
  input  logic [NCH-1:0]              done_set,
  output logic [BUS_W-1:0]            rdata,
  output logic [NCH-1:0][PER_W-1:0]   per_q,
  output logic [NCH-1:0][PER_W-1:0]   low_q,
  output logic [NCH-1:0]              run_q,
  output logic [NCH-1:0]              upd_q,
  output logic [NCH-1:0]              oe_q,
  output logic [NCH-1:0]              pol_q,
  output logic [NCH-1:0]              done_q
);
  localparam int unsigned PAD = BUS_W - PER_W;
  localparam int unsigned BPAD = BUS_W - NCH;

  logic hit_pol, hit_run, hit_done, hit_upd, hit_oe;
  assign hit_pol  = (addr == AW'(OFS_POL));
  assign hit_run  = (addr == AW'(OFS_RUN));
  assign hit_done = (addr == AW'(OFS_DONE));
  assign hit_upd  = (addr == AW'(OFS_UPD));
  assign hit_oe   = (addr == AW'(OFS_OE));

  logic [NCH-1:0] clr_vec;
  assign clr_vec = (wr && hit_done) ? wdata[NCH-1:0] : '0;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_chreg
      logic hit_low, hit_per;
      assign hit_low = (addr == AW'(8 * gi));
      assign hit_per = (addr == AW'(8 * gi + 4));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          low_q[gi] <= '0;
          per_q[gi] <= '0;
        end else if (wr) begin
          if (hit_low) low_q[gi] <= wdata[PER_W-1:0];
          if (hit_per) per_q[gi] <= wdata[PER_W-1:0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      upd_q  <= '0;
      oe_q   <= '0;
      pol_q  <= '0;
      done_q <= '0;
    end else begin
      if (wr && hit_run) run_q <= wdata[NCH-1:0];
      if (wr && hit_upd) upd_q <= wdata[NCH-1:0];
      if (wr && hit_oe)  oe_q  <= wdata[NCH-1:0];
      if (wr && hit_pol) pol_q <= wdata[NCH-1:0];
      done_q <= (done_q & ~clr_vec) | done_set;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(8 * i))     rdata = {{PAD{1'b0}}, low_q[i]};
      if (addr == AW'(8 * i + 4)) rdata = {{PAD{1'b0}}, per_q[i]};
    end
    if (hit_pol)  rdata = {{BPAD{1'b0}}, pol_q};
    if (hit_run)  rdata = {{BPAD{1'b0}}, run_q};
    if (hit_done) rdata = {{BPAD{1'b0}}, done_q};
    if (hit_upd)  rdata = {{BPAD{1'b0}}, upd_q};
    if (hit_oe)   rdata = {{BPAD{1'b0}}, oe_q};
  end
endmodule

// File: rtl/pwm_multi_chan.sv
module pwm_multi_chan
  import pwm_multi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  upd,
  input  logic  oe,
  input  tick_t per_reg,
  input  tick_t low_reg,
  output logic  pin,
  output logic  active,
  output tick_t cnt,
  output tick_t per_w,
  output tick_t low_w,
  output logic  start_evt,
  output logic  apply_evt
);
  logic  upd_prev;
  logic  pend;
  tick_t pend_per, pend_low;
  logic  upd_fall, term;

  assign start_evt = run & ~active;
  assign upd_fall  = upd_prev & ~upd;
  assign term      = at_end(cnt, per_w);
  assign apply_evt = run & active & pend & term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      upd_prev <= 1'b0;
      cnt      <= '0;
      per_w    <= '0;
      low_w    <= '0;
      pend     <= 1'b0;
      pend_per <= '0;
      pend_low <= '0;
    end else begin
      active   <= run;
      upd_prev <= upd;
      if (!run) begin
        cnt  <= '0;
        pend <= 1'b0;
      end else if (start_evt) begin
        per_w <= per_reg;
        low_w <= low_reg;
        cnt   <= '0;
        pend  <= 1'b0;
      end else begin
        cnt <= term ? '0 : tick_t'(cnt + 1'b1);
        if (apply_evt) begin
          per_w <= pend_per;
          low_w <= pend_low;
        end
        if (upd_fall) begin
          pend     <= 1'b1;
          pend_per <= per_reg;
          pend_low <= low_reg;
        end else if (apply_evt) begin
          pend <= 1'b0;
        end
      end
    end
  end

  assign pin = active & oe & drive_high(cnt, per_w, low_w);
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_multi_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    pwm_o
);
  logic [NCH-1:0][PER_W-1:0] per_q, low_q;
  logic [NCH-1:0]            run_q, upd_q, oe_q, pol_q, done_q;

  logic [NCH-1:0][PER_W-1:0] cnt_v, perw_v, loww_v;
  logic [NCH-1:0]            act_v, start_v, apply_v;

  pwm_multi_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .done_set (apply_v),
    .rdata    (bus_rdata),
    .per_q    (per_q),
    .low_q    (low_q),
    .run_q    (run_q),
    .upd_q    (upd_q),
    .oe_q     (oe_q),
    .pol_q    (pol_q),
    .done_q   (done_q)
  );

  genvar gc;
  generate
    for (gc = 0; gc < NCH; gc++) begin : g_ch
      pwm_multi_chan u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q[gc]),
        .upd       (upd_q[gc]),
        .oe        (oe_q[gc]),
        .per_reg   (per_q[gc]),
        .low_reg   (low_q[gc]),
        .pin       (pwm_o[gc]),
        .active    (act_v[gc]),
        .cnt       (cnt_v[gc]),
        .per_w     (perw_v[gc]),
        .low_w     (loww_v[gc]),
        .start_evt (start_v[gc]),
        .apply_evt (apply_v[gc])
      );
    end
  endgenerate
endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk
  import pwm_multi_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            run_q,
  input logic [NCH-1:0]            oe_q,
  input logic [NCH-1:0]            done_q,
  input logic [NCH-1:0][PER_W-1:0] per_q,
  input logic [NCH-1:0]            act_v,
  input logic [NCH-1:0][PER_W-1:0] cnt_v,
  input logic [NCH-1:0][PER_W-1:0] perw_v,
  input logic [NCH-1:0][PER_W-1:0] loww_v,
  input logic [NCH-1:0]            apply_v,
  input logic [NCH-1:0]            pwm_o
);
  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_a
      a_r4_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_q[i] |-> !pwm_o[i]);
      a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q[i] && !$past(run_q[i])) |-> !pwm_o[i]);
      a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_v[i]) |-> (cnt_v[i] == '0 && perw_v[i] == $past(per_q[i])));
      a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (act_v[i] && perw_v[i] != '0) |-> cnt_v[i] < perw_v[i]);
      a_r6_work_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (act_v[i] && run_q[i] && !apply_v[i]) |=> ($stable(perw_v[i]) && $stable(loww_v[i])));
      a_r7_fresh_period: assert property (@(posedge clk) disable iff (!rst_n)
        apply_v[i] |=> cnt_v[i] == '0);
      a_r8_done_set: assert property (@(posedge clk) disable iff (!rst_n)
        apply_v[i] |=> done_q[i]);
      a_r5_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        (act_v[i] && oe_q[i] && loww_v[i] == '0 && perw_v[i] != '0) |-> pwm_o[i]);
    end
  endgenerate
endmodule

bind pwm_multi pwm_multi_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_q   (run_q),
  .oe_q    (oe_q),
  .done_q  (done_q),
  .per_q   (per_q),
  .act_v   (act_v),
  .cnt_v   (cnt_v),
  .perw_v  (perw_v),
  .loww_v  (loww_v),
  .apply_v (apply_v),
  .pwm_o   (pwm_o)
);

// File: tb/tb_pwm_multi.sv
`timescale 1ns/1ps
module tb_pwm_multi;
  localparam int NC = 4;
  localparam logic [7:0] A_POL = 8'h40, A_RUN = 8'h44, A_DONE = 8'h48,
                         A_UPD = 8'h4C, A_OE = 8'hD0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] pwm_o;

  always #2.5 clk = ~clk;

  pwm_multi dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  bit cmp_en = 0;
  string tag = "R1";

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at cycle %0d", t, act, exp, cyc);
    end
  endtask

  // Reference model, fed only by the bus traffic
  logic [31:0]   m_per [NC];
  logic [31:0]   m_low [NC];
  logic [NC-1:0] m_run, m_upd, m_oe, m_pol, m_done;
  logic [31:0]   e_cnt [NC];
  logic [31:0]   e_pw [NC];
  logic [31:0]   e_lw [NC];
  logic [31:0]   e_pp [NC];
  logic [31:0]   e_pl [NC];
  logic [NC-1:0] e_act, e_updp, e_pend;

  function automatic logic level(input logic [31:0] c, input logic [31:0] p, input logic [31:0] l);
    return ({32'b0, c} + {32'b0, l}) < {32'b0, p};
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic [NC-1:0] app;
    logic t;
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_per[c] <= 0; m_low[c] <= 0; e_cnt[c] <= 0; e_pw[c] <= 0;
        e_lw[c] <= 0; e_pp[c] <= 0; e_pl[c] <= 0;
      end
      m_run <= 0; m_upd <= 0; m_oe <= 0; m_pol <= 0; m_done <= 0;
      e_act <= 0; e_updp <= 0; e_pend <= 0;
    end else begin
      app = '0;
      for (int c = 0; c < NC; c++) begin
        t = (e_cnt[c] + 1) >= e_pw[c];
        app[c] = e_act[c] && m_run[c] && e_pend[c] && t;
        e_act[c]  <= m_run[c];
        e_updp[c] <= m_upd[c];
        if (!m_run[c]) begin
          e_cnt[c] <= 0; e_pend[c] <= 0;
        end else if (!e_act[c]) begin
          e_pw[c] <= m_per[c]; e_lw[c] <= m_low[c]; e_cnt[c] <= 0; e_pend[c] <= 0;
        end else begin
          e_cnt[c] <= t ? 0 : e_cnt[c] + 1;
          if (app[c]) begin e_pw[c] <= e_pp[c]; e_lw[c] <= e_pl[c]; end
          if (e_updp[c] && !m_upd[c]) begin
            e_pend[c] <= 1; e_pp[c] <= m_per[c]; e_pl[c] <= m_low[c];
          end else if (app[c]) e_pend[c] <= 0;
        end
        if (bus_wr && bus_addr == 8'(8*c))   m_low[c] <= bus_wdata & 32'h3FFF_FFFF;
        if (bus_wr && bus_addr == 8'(8*c+4)) m_per[c] <= bus_wdata & 32'h3FFF_FFFF;
      end
      if (bus_wr && bus_addr == A_RUN) m_run <= bus_wdata[NC-1:0];
      if (bus_wr && bus_addr == A_UPD) m_upd <= bus_wdata[NC-1:0];
      if (bus_wr && bus_addr == A_OE)  m_oe  <= bus_wdata[NC-1:0];
      if (bus_wr && bus_addr == A_POL) m_pol <= bus_wdata[NC-1:0];
      m_done <= (m_done & ~((bus_wr && bus_addr == A_DONE) ? bus_wdata[NC-1:0] : '0)) | app;
    end
  end

  logic [NC-1:0] exp_out;
  always_comb begin
    for (int c = 0; c < NC; c++)
      exp_out[c] = e_act[c] & m_oe[c] & level(e_cnt[c], e_pw[c], e_lw[c]);
  end

  always @(negedge clk) if (cmp_en) chk(tag, {28'b0, pwm_o}, {28'b0, exp_out});

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !finished) begin
      n_fail++;
      $display("FAIL R1 watchdog: got cycle %0d expected completion", cyc);
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    int hi;
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1", {28'b0, pwm_o}, 32'h0);
    rd(8'h04, d); chk("R1", d, 0);
    rd(A_DONE, d); chk("R1", d, 0);
    cmp_en = 1;

    // R10 widths, R12 map
    tag = "R10";
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R10", d, 32'h3FFF_FFFF);
    wr(A_OE, 32'hFFFF_FFF0);  rd(A_OE, d);  chk("R10", d, 32'h0);
    wr(8'h18, 32'h0000_0003); rd(8'h18, d); chk("R12", d, 32'h3);
    rd(8'h1C, d); chk("R12", d, 32'h0);

    // R2 / R3 channel 0, period 5 low 2
    tag = "R3";
    wr(8'h04, 5); wr(8'h00, 2); wr(A_OE, 4'b0001);
    wr(A_RUN, 4'b0001);
    chk("R2", {31'b0, pwm_o[0]}, 0);
    @(negedge clk);
    chk("R2", {31'b0, pwm_o[0]}, 1);
    hi = 0;
    for (int k = 0; k < 10; k++) begin hi += pwm_o[0]; @(negedge clk); end
    chk("R3", hi, 6);

    // R5 channel 1, low 0
    tag = "R5";
    wr(8'h0C, 4); wr(8'h08, 0); wr(A_OE, 4'b0011); wr(A_RUN, 4'b0011);
    idle(1);
    hi = 0;
    for (int k = 0; k < 9; k++) begin hi += pwm_o[1]; @(negedge clk); end
    chk("R5", hi, 9);

    // R4 channel 2 runs without output enable
    tag = "R4";
    wr(8'h14, 3); wr(8'h10, 1); wr(A_RUN, 4'b0111);
    hi = 0;
    for (int k = 0; k < 8; k++) begin hi += pwm_o[2]; @(negedge clk); end
    chk("R4", hi, 0);

    // R6 new values without update pulse
    tag = "R6";
    wr(8'h04, 7); wr(8'h00, 3);
    rd(8'h04, d); chk("R6", d, 7);
    idle(15);

    // R7 / R8 update pulse
    tag = "R7";
    wr(A_UPD, 4'b0001); wr(A_UPD, 4'b0000);
    idle(14);
    rd(A_DONE, d); chk("R8", d, 32'h1);
    wr(A_DONE, 32'h1);
    rd(A_DONE, d); chk("R8", d, 32'h0);

    // R11 polarity has no effect
    tag = "R11";
    wr(A_POL, 32'hF); rd(A_POL, d); chk("R11", d, 32'hF);
    idle(10);
    wr(A_POL, 0);

    // R9 stop and restart
    tag = "R9";
    wr(A_RUN, 4'b0110);
    idle(1);
    chk("R9", {31'b0, pwm_o[0]}, 0);
    wr(A_RUN, 4'b0111);
    @(negedge clk);
    chk("R9", {31'b0, pwm_o[0]}, 1);

    // R3 fastest waveform on channel 3
    tag = "R3";
    wr(8'h1C, 2); wr(8'h18, 1); wr(A_OE, 4'b1011); wr(A_RUN, 4'b1111);
    @(negedge clk);
    chk("R3", {31'b0, pwm_o[3]}, 1);
    @(negedge clk);
    chk("R3", {31'b0, pwm_o[3]}, 0);

    // Random operations
    tag = "R3";
    for (int it = 0; it < 60; it++) begin
      int ch, op;
      ch = $urandom_range(NC-1, 0);
      op = $urandom_range(5, 0);
      case (op)
        0: wr(8'(8*ch+4), $urandom_range(9, 2));
        1: wr(8'(8*ch), $urandom_range(10, 0));
        2: wr(A_RUN, m_run ^ (4'b1 << ch));
        3: wr(A_OE, m_oe ^ (4'b1 << ch));
        4: begin wr(A_UPD, m_upd | (4'b1 << ch)); wr(A_UPD, m_upd & ~(4'b1 << ch)); end
        default: begin
          rd(A_DONE, d); chk("R8", d, {28'b0, m_done});
          wr(A_DONE, $urandom_range(15, 0));
        end
      endcase
      idle($urandom_range(12, 0));
    end
    rd(A_DONE, d); chk("R8", d, {28'b0, m_done});
    cmp_en = 0;
    finished = 1;
    summary();
  end
endmodule